// File: doc/BRIEF.md
# Saturating PI Current Controller

This block closes one current loop of a field-oriented motor drive: either the d axis or the q axis. Each start pulse captures a current reference, a measured current and the loop settings. The block then forms the error and applies a proportional gain and an integral gain. Each gain has its own binary range shift. The result is a saturated voltage command. The controller keeps its own 32-bit integral state between runs, so one start per control period advances the loop by one step.

The command is clamped to a symmetric window set by a 16-bit limit. Whenever the clamp acts, a sticky flag records it. A programmable share of the clamp excess (none, a quarter, a half or all of it) is folded back into the stored integral, which bounds integrator wind-up. A clear input, or reset, empties the integral and drops the flag. Every run takes the same number of cycles and ends with a one-cycle done pulse.

Top module: `pi_current_axis`

## Requirements
- R1: With err = cur_ref − cur_meas (17-bit signed), the integral candidate is integ_term + S(ki_coef·err·2^(ki_range+1)) and the output candidate is S(integral candidate + S(kp_coef·err·2^(kp_range+1))), all in Q31. S is saturation to 32-bit signed. integ_term changes only at a done pulse or after clear.
- R2: ki_range scales only the integral product and kp_range scales only the proportional product. Each is a left shift of 0 to 15 on top of the Q30-to-Q31 shift of one.
- R3: The limit in Q31 is v_limit·2^16, or 0 when v_limit is negative. An output candidate above +limit yields +limit and one below −limit yields −limit. Otherwise the candidate passes unchanged.
- R4: sat_flag sets when a clamp acts and then stays at 1 until clear or reset.
- R5: The stored integral becomes S(integral candidate + share), where share is (clamped − candidate) arithmetically shifted right. aw_ratio 0 gives no share, 1 gives a shift of 2, 2 gives a shift of 1 and 3 gives the whole excess.
- R6: When kp_range is 2 or more, v_cmd is S(clamped output · kp_range). Otherwise v_cmd is the clamped output.
- R7: Every intermediate sum and scaled product saturates to the 32-bit signed range and never wraps.
- R8: All inputs are sampled on the clock edge where start is accepted. done is high for exactly one cycle, the third cycle after that edge, and v_cmd, integ_term and sat_flag update together with it.
- R9: A start raised while a run is still in its first two stages is ignored. It produces no extra done and no extra update.
- R10: A cycle of clear sets integ_term to 0 and sat_flag to 0 from the next edge on.
- R11: After reset, v_cmd, integ_term, sat_flag and done are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin one controller step |
| clear | input | 1 | Zero the integral state and the overflow flag |
| cur_ref | input | 16 | Current reference, signed Q15 |
| cur_meas | input | 16 | Measured current, signed Q15 |
| kp_coef | input | 16 | Proportional coefficient, signed Q15 |
| ki_coef | input | 16 | Integral coefficient, signed Q15 |
| kp_range | input | 4 | Proportional range shift |
| ki_range | input | 4 | Integral range shift |
| v_limit | input | 16 | Output limit magnitude, signed Q15 |
| aw_ratio | input | 2 | Anti-windup feedback share select |
| done | output | 1 | One-cycle completion pulse |
| v_cmd | output | 32 | Voltage command, signed Q31 |
| integ_term | output | 32 | Stored integral term, signed Q31 |
| sat_flag | output | 1 | Sticky clamp flag |

## Verification
The bench builds the block with its default widths: 16-bit data, a 32-bit accumulator and 4-bit range fields. At these widths the full-scale error of 65535 combined with a range of 15 drives the scaled products far past 32 bits, so the saturation of every sum is reachable. The 16-bit shift between limit and Q31 output is exercised with both positive and negative limits. All four anti-windup shares, the range compensation multiply and the ignored restart are run against a model computed from the requirements.

// File: rtl/pi_axis_pkg.sv
package pi_axis_pkg;

  // Share of the clamp excess returned to the integrator
  typedef enum logic [1:0] {
    AW_NONE    = 2'd0,
    AW_QUARTER = 2'd1,
    AW_HALF    = 2'd2,
    AW_FULL    = 2'd3
  } aw_frac_e;

  localparam int GAIN_INT  = 0;
  localparam int GAIN_PROP = 1;
  localparam int N_GAINS   = 2;

endpackage

// File: rtl/pi_sat.sv
module pi_sat #(
  parameter int IW = 33,
  parameter int OW = 32
) (
  input  logic signed [IW-1:0] din,
  output logic signed [OW-1:0] dout
);

  localparam int TW = IW - OW + 1;

  logic [TW-1:0] top_bits;
  logic          clip;

  assign top_bits = din[IW-1:OW-1];
  assign clip     = !((&top_bits) || (~|top_bits));
  assign dout     = clip ? {din[IW-1], {(OW-1){~din[IW-1]}}} : din[OW-1:0];

endmodule

// File: rtl/pi_gain_scale.sv
module pi_gain_scale #(
  parameter int DW = 16,
  parameter int OW = 32,
  parameter int RW = 4
) (
  input  logic signed [DW-1:0] coef,
  input  logic signed [DW:0]   err,
  input  logic        [RW-1:0] rng,
  output logic signed [OW-1:0] term
);

  localparam int PW   = 2 * DW + 1;
  localparam int BASE = (OW - 1) - 2 * (DW - 1);
  localparam int SW   = PW + (1 << RW) - 1 + BASE;

  logic signed [PW-1:0] prod;
  logic signed [SW-1:0] ext;
  logic signed [SW-1:0] shl;

  always_comb begin
    prod = coef * err;
    ext  = {{(SW-PW){prod[PW-1]}}, prod};
    shl  = ext <<< (int'(rng) + BASE);
  end

  pi_sat #(.IW(SW), .OW(OW)) u_sat (
    .din  (shl),
    .dout (term)
  );

endmodule

// File: rtl/pi_clamp_aw.sv
module pi_clamp_aw
  import pi_axis_pkg::*;
#(
  parameter int DW = 16,
  parameter int OW = 32,
  parameter int RW = 4
) (
  input  logic signed [OW-1:0] icand,
  input  logic signed [OW-1:0] pterm,
  input  logic signed [DW-1:0] lim,
  input  aw_frac_e             ratio,
  input  logic        [RW-1:0] kprng,
  output logic signed [OW-1:0] vout,
  output logic signed [OW-1:0] integ_nx,
  output logic                 over
);

  localparam int LIM_SH = OW - DW;
  localparam int KW     = OW + RW + 1;

  logic signed [OW:0]   osum;
  logic signed [OW-1:0] ocand;
  logic signed [OW-1:0] limw;
  logic signed [OW-1:0] nlimw;
  logic signed [OW-1:0] held;
  logic signed [OW:0]   excess;
  logic signed [OW:0]   share;
  logic signed [OW+1:0] isum;
  logic signed [KW-1:0] kprod;
  logic signed [OW-1:0] ksat;

  assign osum = {icand[OW-1], icand} + {pterm[OW-1], pterm};

  pi_sat #(.IW(OW+1), .OW(OW)) u_osat (.din(osum), .dout(ocand));

  always_comb begin
    limw  = lim[DW-1] ? '0 : {lim, {LIM_SH{1'b0}}};
    nlimw = -limw;
    over  = 1'b0;
    held  = ocand;
    if (ocand > limw) begin
      held = limw;
      over = 1'b1;
    end else if (ocand < nlimw) begin
      held = nlimw;
      over = 1'b1;
    end
    excess = {held[OW-1], held} - {ocand[OW-1], ocand};
    case (ratio)
      AW_QUARTER: share = excess >>> 2;
      AW_HALF:    share = excess >>> 1;
      AW_FULL:    share = excess;
      default:    share = '0;
    endcase
    isum  = {{2{icand[OW-1]}}, icand} + {share[OW], share};
    kprod = held * $signed({1'b0, kprng});
  end

  pi_sat #(.IW(OW+2), .OW(OW)) u_isat (.din(isum),  .dout(integ_nx));
  pi_sat #(.IW(KW),   .OW(OW)) u_ksat (.din(kprod), .dout(ksat));

  assign vout = (kprng >= RW'(2)) ? ksat : held;

endmodule

// File: rtl/pi_current_axis.sv
module pi_current_axis
  import pi_axis_pkg::*;
#(
  parameter int DW = 16,
  parameter int OW = 32,
  parameter int RW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 clear,
  input  logic signed [DW-1:0] cur_ref,
  input  logic signed [DW-1:0] cur_meas,
  input  logic signed [DW-1:0] kp_coef,
  input  logic signed [DW-1:0] ki_coef,
  input  logic        [RW-1:0] kp_range,
  input  logic        [RW-1:0] ki_range,
  input  logic signed [DW-1:0] v_limit,
  input  logic        [1:0]    aw_ratio,
  output logic                 done,
  output logic signed [OW-1:0] v_cmd,
  output logic signed [OW-1:0] integ_term,
  output logic                 sat_flag
);

  // reset synchronizer: assert async, release on clock
  logic [1:0] rs_q;
  logic       arst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign arst_n_s = rs_q[1];

  // stage valid chain
  logic v1_q, v2_q, v3_q;
  logic busy, take;

  assign busy = v1_q | v2_q;
  assign take = start & ~busy & arst_n_s;

  always_ff @(posedge clk or negedge arst_n_s) begin
    if (!arst_n_s) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else begin
      v1_q <= take;
      v2_q <= v1_q;
      v3_q <= v2_q;
    end
  end
  assign done = v3_q;

  // stage 1: capture error and settings
  logic signed [DW:0]   err_d, err_q;
  logic signed [DW-1:0] coef_q [N_GAINS];
  logic        [RW-1:0] rng_q  [N_GAINS];
  logic signed [DW-1:0] lim1_q;
  aw_frac_e             ratio1_q;

  assign err_d = {cur_ref[DW-1], cur_ref} - {cur_meas[DW-1], cur_meas};

  always_ff @(posedge clk or negedge arst_n_s) begin
    if (!arst_n_s) begin
      err_q     <= '0;
      coef_q[0] <= '0;
      coef_q[1] <= '0;
      rng_q[0]  <= '0;
      rng_q[1]  <= '0;
      lim1_q    <= '0;
      ratio1_q  <= AW_NONE;
    end else if (take) begin
      err_q               <= err_d;
      coef_q[GAIN_INT]    <= ki_coef;
      coef_q[GAIN_PROP]   <= kp_coef;
      rng_q[GAIN_INT]     <= ki_range;
      rng_q[GAIN_PROP]    <= kp_range;
      lim1_q              <= v_limit;
      ratio1_q            <= aw_frac_e'(aw_ratio);
    end
  end

  // stage 2: scaled gain terms and integral candidate
  logic signed [OW-1:0] term [N_GAINS];

  for (genvar g = 0; g < N_GAINS; g++) begin : g_gain
    pi_gain_scale #(.DW(DW), .OW(OW), .RW(RW)) u_scale (
      .coef (coef_q[g]),
      .err  (err_q),
      .rng  (rng_q[g]),
      .term (term[g])
    );
  end

  logic signed [OW-1:0] integ_q;
  logic signed [OW:0]   icsum;
  logic signed [OW-1:0] icand_d;

  assign icsum = {integ_q[OW-1], integ_q} + {term[GAIN_INT][OW-1], term[GAIN_INT]};

  pi_sat #(.IW(OW+1), .OW(OW)) u_icsat (.din(icsum), .dout(icand_d));

  logic signed [OW-1:0] icand_q, pterm_q;
  logic signed [DW-1:0] lim2_q;
  aw_frac_e             ratio2_q;
  logic        [RW-1:0] kprng2_q;

  always_ff @(posedge clk or negedge arst_n_s) begin
    if (!arst_n_s) begin
      icand_q  <= '0;
      pterm_q  <= '0;
      lim2_q   <= '0;
      ratio2_q <= AW_NONE;
      kprng2_q <= '0;
    end else if (v1_q) begin
      icand_q  <= icand_d;
      pterm_q  <= term[GAIN_PROP];
      lim2_q   <= lim1_q;
      ratio2_q <= ratio1_q;
      kprng2_q <= rng_q[GAIN_PROP];
    end
  end

  // stage 3: clamp, anti-windup, range compensation
  logic signed [OW-1:0] vout_d, integ_nx, integ_d, vout_q;
  logic                 over_d, flag_d, flag_q;

  pi_clamp_aw #(.DW(DW), .OW(OW), .RW(RW)) u_clamp (
    .icand    (icand_q),
    .pterm    (pterm_q),
    .lim      (lim2_q),
    .ratio    (ratio2_q),
    .kprng    (kprng2_q),
    .vout     (vout_d),
    .integ_nx (integ_nx),
    .over     (over_d)
  );

  always_comb begin
    integ_d = integ_q;
    flag_d  = flag_q;
    if (clear) begin
      integ_d = '0;
      flag_d  = 1'b0;
    end else if (v2_q) begin
      integ_d = integ_nx;
      flag_d  = flag_q | over_d;
    end
  end

  always_ff @(posedge clk or negedge arst_n_s) begin
    if (!arst_n_s) begin
      integ_q <= '0;
      flag_q  <= 1'b0;
      vout_q  <= '0;
    end else begin
      integ_q <= integ_d;
      flag_q  <= flag_d;
      if (v2_q) vout_q <= vout_d;
    end
  end

  assign v_cmd      = vout_q;
  assign integ_term = integ_q;
  assign sat_flag   = flag_q;

endmodule

// File: rtl/pi_current_axis_chk.sv
module pi_current_axis_chk #(
  parameter int OW = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 arst_n_s,
  input logic                 start,
  input logic                 busy,
  input logic                 clear,
  input logic                 done,
  input logic                 sat_flag,
  input logic signed [OW-1:0] integ_term
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && arst_n_s) |-> ##3 done); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !clear) |=> sat_flag); // R4

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (integ_term == '0 && !sat_flag)); // R10

  AST_INTEG_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(integ_term) |-> (done || $past(clear))); // R1

endmodule

bind pi_current_axis pi_current_axis_chk #(.OW(OW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .arst_n_s   (arst_n_s),
  .start      (start),
  .busy       (busy),
  .clear      (clear),
  .done       (done),
  .sat_flag   (sat_flag),
  .integ_term (integ_term)
);

// File: tb/test_pi_current_axis.sv
module test_pi_current_axis;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               start, clear;
  logic signed [15:0] cur_ref, cur_meas, kp_coef, ki_coef, v_limit;
  logic        [3:0]  kp_range, ki_range;
  logic        [1:0]  aw_ratio;
  logic               done, sat_flag;
  logic signed [31:0] v_cmd, integ_term;

  always #10 clk = ~clk;   // 20 ns period, 50 MHz

  pi_current_axis i_pi_current_axis (
    .clk(clk), .rst_n(rst_n), .start(start), .clear(clear),
    .cur_ref(cur_ref), .cur_meas(cur_meas), .kp_coef(kp_coef), .ki_coef(ki_coef),
    .kp_range(kp_range), .ki_range(ki_range), .v_limit(v_limit), .aw_ratio(aw_ratio),
    .done(done), .v_cmd(v_cmd), .integ_term(integ_term), .sat_flag(sat_flag)
  );

  int     n_chk = 0;
  int     n_err = 0;
  bit     finished = 1'b0;
  longint m_integ = 0;
  bit     m_flag = 1'b0;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic longint sat32(input longint x);
    if (x > 64'sd2147483647) return 64'sd2147483647;
    if (x < -64'sd2147483648) return -64'sd2147483648;
    return x;
  endfunction

  // reference model built from the requirements
  function automatic longint model(input int r, input int f, input int kp, input int ki,
                                   input int kr, input int ir, input int lim, input int ratio);
    longint err = longint'(r) - longint'(f);
    longint kt  = sat32((longint'(ki) * err) <<< (ir + 1));
    longint ic  = sat32(m_integ + kt);
    longint pt  = sat32((longint'(kp) * err) <<< (kr + 1));
    longint oc  = sat32(ic + pt);
    longint lw  = (lim < 0) ? 64'sd0 : (longint'(lim) <<< 16);
    longint outv = oc;
    longint ex, sh;
    if (oc > lw) begin
      outv = lw; m_flag = 1'b1;
    end else if (oc < -lw) begin
      outv = -lw; m_flag = 1'b1;
    end
    ex = outv - oc;
    case (ratio)
      1:       sh = ex >>> 2;
      2:       sh = ex >>> 1;
      3:       sh = ex;
      default: sh = 0;
    endcase
    m_integ = sat32(ic + sh);
    return (kr >= 2) ? sat32(outv * kr) : outv;
  endfunction

  task automatic run_op(input int r, input int f, input int kp, input int ki, input int kr,
                        input int ir, input int lim, input int ratio, input string tag,
                        input bit poke);
    longint exp_v;
    @(negedge clk);
    cur_ref = 16'(r); cur_meas = 16'(f); kp_coef = 16'(kp); ki_coef = 16'(ki);
    kp_range = 4'(kr); ki_range = 4'(ir); v_limit = 16'(lim); aw_ratio = 2'(ratio);
    start = 1'b1;
    @(negedge clk);
    start = poke;
    if (poke) begin  // R8: later inputs must not matter; R9: restart ignored
      cur_ref = 16'sh7fff; cur_meas = 16'sh8000; kp_coef = 16'sh7fff; ki_coef = 16'sh7fff;
      kp_range = 4'd15; ki_range = 4'd15; v_limit = 16'sh7fff; aw_ratio = 2'd3;
    end
    chk("R8", "done early (1)", done, 0);
    @(negedge clk);
    chk("R8", "done early (2)", done, 0);
    @(negedge clk);
    start = 1'b0;
    chk("R8", "done at third cycle", done, 1);
    exp_v = model(r, f, kp, ki, kr, ir, lim, ratio);
    chk(tag, "v_cmd", v_cmd, exp_v);
    chk(tag, "integ_term", integ_term, m_integ);
    chk(tag, "sat_flag", sat_flag, m_flag);
    @(negedge clk);
    chk("R8", "done single cycle", done, 0);
    if (poke) begin
      repeat (3) begin
        @(negedge clk);
        chk("R9", "no extra done", done, 0);
      end
      chk("R9", "integ unchanged", integ_term, m_integ);
    end
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    chk("R10", "integ after clear", integ_term, 0);
    chk("R10", "flag after clear", sat_flag, 0);
    m_integ = 0;
    m_flag  = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11", "v_cmd", v_cmd, 0);
    chk("R11", "integ_term", integ_term, 0);
    chk("R11", "sat_flag", sat_flag, 0);
    chk("R11", "done", done, 0);
  endtask

  task automatic t_prop();
    run_op(16'h1000, 0, 16'h4000, 0, 0, 0, 16'h7fff, 0, "R1", 0);
    chk("R1", "proportional Q31 value", v_cmd, 64'sh0800_0000);
    run_op(-1000, 3000, 16'h2000, 0, 0, 0, 16'h7fff, 0, "R1", 0);
  endtask

  task automatic t_integral();
    do_clear();
    run_op(2000, 500, 16'h1000, 16'h0800, 0, 0, 16'h7fff, 0, "R1", 0);
    run_op(2000, 900, 16'h1000, 16'h0800, 0, 0, 16'h7fff, 0, "R1", 0);
    run_op(-300, 700, 16'h1000, 16'h0800, 0, 0, 16'h7fff, 0, "R1", 0);
  endtask

  task automatic t_ranges();
    do_clear();
    run_op(400, 100, 16'h0400, 16'h0100, 1, 3, 16'h7fff, 0, "R2", 0);
    run_op(400, 100, 16'h0400, 16'h0100, 0, 5, 16'h7fff, 0, "R2", 0);
    run_op(-50, 20, 16'h0200, -16'h0100, 1, 0, 16'h7fff, 0, "R2", 0);
  endtask

  task automatic t_clamp();
    do_clear();
    run_op(16'h3000, -16'h3000, 16'h7fff, 0, 0, 0, 16'h1000, 0, "R3", 0);
    chk("R3", "positive clamp value", v_cmd, 64'sh1000_0000);
    chk("R4", "flag set on clamp", sat_flag, 1);
    run_op(-16'h3000, 16'h3000, 16'h7fff, 0, 0, 0, 16'h1000, 0, "R3", 0);
    chk("R3", "negative clamp value", v_cmd, -64'sh1000_0000);
    run_op(10, 0, 16'h0100, 0, 0, 0, 16'h7fff, 0, "R4", 0);
    chk("R4", "flag sticky", sat_flag, 1);
    do_clear();
    run_op(100, 0, 16'h0100, 0, 0, 0, -5, 0, "R3", 0);
    chk("R3", "negative limit gives zero", v_cmd, 0);
  endtask

  task automatic t_antiwindup();
    for (int k = 0; k < 4; k++) begin
      do_clear();
      run_op(16'h2000, 0, 16'h4000, 16'h2000, 0, 2, 16'h0800, k, "R5", 0);
      run_op(16'h2000, 0, 16'h4000, 16'h2000, 0, 2, 16'h0800, k, "R5", 0);
    end
  endtask

  task automatic t_kpcomp();
    do_clear();
    run_op(300, 0, 16'h0400, 0, 2, 0, 16'h7fff, 0, "R6", 0);
    run_op(300, 0, 16'h0400, 0, 3, 0, 16'h7fff, 0, "R6", 0);
    run_op(16'h4000, 0, 16'h7fff, 0, 15, 0, 16'h7000, 0, "R6", 0);
  endtask

  task automatic t_saturate();
    do_clear();
    run_op(16'h7fff, -16'h8000, 16'h7fff, 16'h7fff, 15, 15, 16'h7fff, 0, "R7", 0);
    chk("R7", "integral saturated high", integ_term, 64'sd2147483647);
    run_op(-16'h8000, 16'h7fff, 16'h7fff, 16'h7fff, 15, 15, 16'h7fff, 0, "R7", 0);
    run_op(-16'h8000, 16'h7fff, 16'h7fff, 16'h7fff, 15, 15, 16'h7fff, 0, "R7", 0);
  endtask

  task automatic t_busy();
    do_clear();
    run_op(1500, 200, 16'h0800, 16'h0400, 1, 1, 16'h7fff, 2, "R9", 1);
    run_op(800, 100, 16'h0800, 16'h0400, 0, 0, 16'h7fff, 0, "R8", 0);
  endtask

  task automatic t_clear();
    run_op(16'h3000, 0, 16'h7fff, 16'h4000, 0, 0, 16'h0400, 0, "R10", 0);
    do_clear();
    run_op(0, 0, 16'h1000, 16'h1000, 0, 0, 16'h7fff, 0, "R10", 0);
    chk("R10", "integral restarts from zero", integ_term, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; clear = 1'b0;
    cur_ref = '0; cur_meas = '0; kp_coef = '0; ki_coef = '0;
    kp_range = '0; ki_range = '0; v_limit = '0; aw_ratio = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_prop();
    t_integral();
    t_ranges();
    t_clamp();
    t_antiwindup();
    t_kpcomp();
    t_saturate();
    t_busy();
    t_clear();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule